// File: doc/BRIEF.md
# JTAG Test Access Port with Identification Word

This block is the boundary-scan test access port of a programmable logic device. A 16-state controller advances on each rising edge of the test clock under the mode-select input. A 4-bit instruction register picks one of several data registers to sit between the serial input and the serial output: a one-bit bypass stage, a 32-bit identification word, a status register that snapshots the device configuration state, and a boundary chain that stands in for the pad cells. Each data register moves only while its own instruction is selected.

The identification word is assembled at elaboration time from four parameter fields: die version, family, array size and manufacturer. A configure instruction sends a one-cycle start pulse to the configuration engine when Update-IR completes. An external disable input blocks that pulse. Loading the instruction again sends a new pulse, which restarts an attempt that did not finish. The serial output changes on the falling edge of the test clock and is enabled only while a register is shifting.

Top module: `jtag_tap_id`

## Requirements
- R1: The identification word is {version[3:0], family[6:0], array_dim[8:0], manufacturer[10:0], 1'b1}, with the MSB on the left. With the default parameters (version 0, family 02h, array 014h, manufacturer 049h) the word is 00414093h. It is shifted out LSB first.
- R2: Five rising test-clock edges with tms high reach Test-Logic-Reset from any state. Asynchronous reset (rst_n low) also reaches Test-Logic-Reset. Either way, IDCODE becomes the current instruction, so the next data scan returns the identification word.
- R3: Without rising test-clock edges the controller state and all registers hold, whatever tms does.
- R4: Capture-IR loads 4'b0001, which is shifted out LSB first. The opcodes are EXTEST 0000, SAMPLE 0001, IDCODE 0010, STATUS 0011, CONFIG 0101 and BYPASS 1111. Any other opcode selects the bypass stage.
- R5: The bypass stage is one bit long and loads 0 in Capture-DR. With the default values, 8 bits A5h shifted in return 4Ah. The stage moves only while the bypass path is selected.
- R6: The boundary chain (BSR_LEN bits) loads bsr_pi in Capture-DR. It shifts and drives bsr_po at Update-DR only under EXTEST or SAMPLE. Under any other instruction bsr_po holds its value.
- R7: The STATUS instruction captures cfg_state_i into an STAT_W-bit register in Capture-DR, which is then shifted out LSB first.
- R8: An Update-IR that loads CONFIG while cfg_disable_i is low raises cfg_start_o for exactly one test-clock cycle after that edge. Loading CONFIG again raises it again.
- R9: While cfg_disable_i is high, loading CONFIG leaves cfg_start_o low.
- R10: tdo and tdo_en change only on the falling test-clock edge. tdo_en is high only in Shift-IR or Shift-DR, and tdo is 0 whenever tdo_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| cfg_state_i | input | STAT_W | Configuration state, captured by the STATUS instruction |
| cfg_disable_i | input | 1 | Blocks the configure start pulse |
| bsr_pi | input | BSR_LEN | Values presented to the boundary chain at capture |
| bsr_po | output | BSR_LEN | Boundary update latch outputs |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_en | output | 1 | Output enable for tdo |
| cfg_start_o | output | 1 | One-cycle configure start pulse |

## Verification
The hardest condition to reach from the ports is a change of tms with the test clock frozen in the middle of a shift. The bench generates its own test clock, so it can stop that clock while the controller sits in Shift-DR partway through the identification word. It then toggles tms several times, restarts the clock and finishes the scan. The word must come back complete and in order. The per-instruction gating of the boundary chain is also hard to see directly. To expose it, the bench preloads the chain and then runs full data scans, including Update-DR, under other instructions. bsr_po must keep the preloaded value.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W = 4;
    typedef logic [IR_W-1:0] opcode_t;

    localparam opcode_t OP_EXTEST  = 4'h0;
    localparam opcode_t OP_SAMPLE  = 4'h1;
    localparam opcode_t OP_IDCODE  = 4'h2;
    localparam opcode_t OP_STATUS  = 4'h3;
    localparam opcode_t OP_CONFIG  = 4'h5;
    localparam opcode_t OP_BYPASS  = 4'hF;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        DR_BYPASS, DR_IDCODE, DR_BOUNDARY, DR_STATUS, DR_CONFIG
    } dr_sel_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_TLR:    n = m ? ST_TLR    : ST_RTI;
            ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  n = m ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  n = m ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic dr_sel_e decode_op(input opcode_t op);
        dr_sel_e s;
        case (op)
            OP_EXTEST, OP_SAMPLE: s = DR_BOUNDARY;
            OP_IDCODE:            s = DR_IDCODE;
            OP_STATUS:            s = DR_STATUS;
            OP_CONFIG:            s = DR_CONFIG;
            default:              s = DR_BYPASS;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e state;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.state = tap_next(r_q.state, tms);
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_TLR};
        else        r_q <= r_d;
    end

    assign state_o = r_q.state;

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tdi,
    input  tap_state_e state_i,
    input  logic       cfg_disable_i,
    output opcode_t    ir_o,
    output logic       ir_tdo_o,
    output logic       cfg_start_o
);

    typedef struct packed {
        opcode_t sh;
        opcode_t ir;
        logic    start;
    } ir_regs_t;

    ir_regs_t r_d, r_q;
    logic [IR_W:0] shift_w;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        shift_w   = {tdi, r_q.sh};
        case (state_i)
            ST_TLR:    r_d.ir = OP_IDCODE;
            ST_CAP_IR: r_d.sh = opcode_t'(1);
            ST_SH_IR:  r_d.sh = shift_w[IR_W:1];
            ST_UPD_IR: begin
                r_d.ir    = r_q.sh;
                r_d.start = (r_q.sh == OP_CONFIG) && !cfg_disable_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{sh: '0, ir: OP_IDCODE, start: 1'b0};
        else        r_q <= r_d;
    end

    assign ir_o        = r_q.ir;
    assign ir_tdo_o    = r_q.sh[0];
    assign cfg_start_o = r_q.start;

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_LEN = 8,
    parameter int          STAT_W  = 4,
    parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tdi,
    input  tap_state_e         state_i,
    input  dr_sel_e            sel_i,
    input  logic [STAT_W-1:0]  cfg_state_i,
    input  logic [BSR_LEN-1:0] bsr_pi,
    output logic [BSR_LEN-1:0] bsr_po,
    output logic               dr_tdo_o
);

    localparam int ID_W = 32;

    typedef struct packed {
        logic               byp;
        logic [ID_W-1:0]    id;
        logic [STAT_W-1:0]  stat;
        logic [BSR_LEN-1:0] bsr_sh;
        logic [BSR_LEN-1:0] bsr_upd;
    } dr_regs_t;

    dr_regs_t r_d, r_q;

    // Per-register clock enables: each register moves only under its own instruction
    logic en_byp, en_id, en_stat, en_bsr;
    logic [ID_W:0]    id_shift;
    logic [STAT_W:0]  stat_shift;
    logic [BSR_LEN:0] bsr_shift;

    assign en_byp  = (sel_i == DR_BYPASS);
    assign en_id   = (sel_i == DR_IDCODE);
    assign en_stat = (sel_i == DR_STATUS);
    assign en_bsr  = (sel_i == DR_BOUNDARY);

    always_comb begin
        r_d        = r_q;
        id_shift   = {tdi, r_q.id};
        stat_shift = {tdi, r_q.stat};
        bsr_shift  = {tdi, r_q.bsr_sh};
        if (en_byp) begin
            if (state_i == ST_CAP_DR) r_d.byp = 1'b0;
            if (state_i == ST_SH_DR)  r_d.byp = tdi;
        end
        if (en_id) begin
            if (state_i == ST_CAP_DR) r_d.id = ID_WORD;
            if (state_i == ST_SH_DR)  r_d.id = id_shift[ID_W:1];
        end
        if (en_stat) begin
            if (state_i == ST_CAP_DR) r_d.stat = cfg_state_i;
            if (state_i == ST_SH_DR)  r_d.stat = stat_shift[STAT_W:1];
        end
        if (en_bsr) begin
            if (state_i == ST_CAP_DR) r_d.bsr_sh  = bsr_pi;
            if (state_i == ST_SH_DR)  r_d.bsr_sh  = bsr_shift[BSR_LEN:1];
            if (state_i == ST_UPD_DR) r_d.bsr_upd = r_q.bsr_sh;
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (sel_i)
            DR_BYPASS:   dr_tdo_o = r_q.byp;
            DR_IDCODE:   dr_tdo_o = r_q.id[0];
            DR_STATUS:   dr_tdo_o = r_q.stat[0];
            DR_BOUNDARY: dr_tdo_o = r_q.bsr_sh[0];
            default:     dr_tdo_o = 1'b0;
        endcase
    end

    assign bsr_po = r_q.bsr_upd;

endmodule

// File: rtl/jtag_tap_id.sv
module jtag_tap_id
    import jtag_tap_pkg::*;
#(
    parameter logic [3:0]  VERSION   = 4'h0,
    parameter logic [6:0]  FAMILY    = 7'h02,
    parameter logic [8:0]  ARRAY_DIM = 9'h014,
    parameter logic [10:0] MFR       = 11'h049,
    parameter int          BSR_LEN   = 8,
    parameter int          STAT_W    = 4
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [STAT_W-1:0]  cfg_state_i,
    input  logic               cfg_disable_i,
    input  logic [BSR_LEN-1:0] bsr_pi,
    output logic [BSR_LEN-1:0] bsr_po,
    output logic               tdo,
    output logic               tdo_en,
    output logic               cfg_start_o
);

    localparam logic [31:0] ID_WORD = {VERSION, FAMILY, ARRAY_DIM, MFR, 1'b1};

    tap_state_e tap_state;
    opcode_t    ir_op;
    dr_sel_e    dr_sel;
    logic       ir_tdo, dr_tdo;

    jtag_tap_fsm u_fsm (
        .tck     (tck),
        .rst_n   (rst_n),
        .tms     (tms),
        .state_o (tap_state)
    );

    jtag_tap_ir u_ir (
        .tck           (tck),
        .rst_n         (rst_n),
        .tdi           (tdi),
        .state_i       (tap_state),
        .cfg_disable_i (cfg_disable_i),
        .ir_o          (ir_op),
        .ir_tdo_o      (ir_tdo),
        .cfg_start_o   (cfg_start_o)
    );

    assign dr_sel = decode_op(ir_op);

    jtag_tap_dr #(
        .BSR_LEN (BSR_LEN),
        .STAT_W  (STAT_W),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .tck         (tck),
        .rst_n       (rst_n),
        .tdi         (tdi),
        .state_i     (tap_state),
        .sel_i       (dr_sel),
        .cfg_state_i (cfg_state_i),
        .bsr_pi      (bsr_pi),
        .bsr_po      (bsr_po),
        .dr_tdo_o    (dr_tdo)
    );

    // Serial output stage, retimed to the falling edge
    typedef struct packed {
        logic tdo;
        logic en;
    } out_regs_t;

    out_regs_t o_d, o_q;

    always_comb begin
        o_d.en  = (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);
        o_d.tdo = (tap_state == ST_SH_IR) ? ir_tdo :
                  (tap_state == ST_SH_DR) ? dr_tdo : 1'b0;
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign tdo    = o_q.tdo;
    assign tdo_en = o_q.en;

endmodule

// File: rtl/jtag_tap_sva.sv
module jtag_tap_sva
    import jtag_tap_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input logic               tck,
    input logic               rst_n,
    input logic               tms,
    input tap_state_e         state,
    input dr_sel_e            sel,
    input opcode_t            ir,
    input logic               tdo,
    input logic               tdo_en,
    input logic [BSR_LEN-1:0] bsr_po,
    input logic               cfg_disable_i,
    input logic               cfg_start_o
);

    // R2: five high tms samples force Test-Logic-Reset
    a_r2_tms_reset: assert property (@(posedge tck) disable iff (!rst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state == ST_TLR));

    // R2: Test-Logic-Reset installs IDCODE
    a_r2_tlr_idcode: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(state) == ST_TLR) |-> (ir == OP_IDCODE));

    // R10: output enable tracks shift states
    a_r10_en_shift: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en == ((state == ST_SH_DR) || (state == ST_SH_IR)));

    // R10: quiet output while disabled
    a_r10_tdo_quiet: assert property (@(posedge tck) disable iff (!rst_n)
        !tdo_en |-> !tdo);

    // R8, R9: start pulse only follows an enabled Update-IR
    a_r9_start_gated: assert property (@(posedge tck) disable iff (!rst_n)
        cfg_start_o |-> (($past(state) == ST_UPD_IR) && !$past(cfg_disable_i)));

    // R8: pulse lasts one cycle unless the previous cycle was Update-IR
    a_r8_single_pulse: assert property (@(posedge tck) disable iff (!rst_n)
        cfg_start_o |=> (!cfg_start_o || ($past(state) == ST_UPD_IR)));

    // R6: boundary outputs move only on a boundary Update-DR
    a_r6_bsr_hold: assert property (@(posedge tck) disable iff (!rst_n)
        !(($past(state) == ST_UPD_DR) && ($past(sel) == DR_BOUNDARY)) |-> $stable(bsr_po));

endmodule

bind jtag_tap_id jtag_tap_sva #(.BSR_LEN(BSR_LEN)) u_sva (
    .tck           (tck),
    .rst_n         (rst_n),
    .tms           (tms),
    .state         (tap_state),
    .sel           (dr_sel),
    .ir            (ir_op),
    .tdo           (tdo),
    .tdo_en        (tdo_en),
    .bsr_po        (bsr_po),
    .cfg_disable_i (cfg_disable_i),
    .cfg_start_o   (cfg_start_o)
);

// File: tb/tb_jtag_tap_id.sv
module tb_jtag_tap_id;

    localparam int          BSR_LEN = 8;
    localparam int          STAT_W  = 4;
    localparam logic [31:0] EXP_ID  = 32'h0041_4093;

    logic tck = 1'b0;
    logic tck_run = 1'b1;
    logic rst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [STAT_W-1:0]  cfg_state = 4'hA;
    logic               cfg_dis = 1'b0;
    logic [BSR_LEN-1:0] bsr_pi = 8'h96;
    logic [BSR_LEN-1:0] bsr_po;
    logic tdo, tdo_en, cfg_start;

    int n_chk = 0;
    int n_bad = 0;

    jtag_tap_id dut (
        .tck           (tck),
        .rst_n         (rst_n),
        .tms           (tms),
        .tdi           (tdi),
        .cfg_state_i   (cfg_state),
        .cfg_disable_i (cfg_dis),
        .bsr_pi        (bsr_pi),
        .bsr_po        (bsr_po),
        .tdo           (tdo),
        .tdo_en        (tdo_en),
        .cfg_start_o   (cfg_start)
    );

    // 100 MHz test clock that the bench can freeze
    initial forever begin
        #5;
        if (tck_run) tck = ~tck;
    end

    typedef struct packed {
        logic [3:0]  op;
        int          len;
        logic [63:0] din;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{op: 4'h2, len: 32, din: 64'h0,  exp: 64'h0041_4093},  // R1 IDCODE
        '{op: 4'hF, len: 8,  din: 64'hA5, exp: 64'h4A},         // R5 BYPASS
        '{op: 4'hA, len: 8,  din: 64'hA5, exp: 64'h4A},         // R4 unknown -> bypass
        '{op: 4'h3, len: 4,  din: 64'h0,  exp: 64'hA},          // R7 STATUS
        '{op: 4'h1, len: 8,  din: 64'h3C, exp: 64'h96}          // R6 SAMPLE capture
    };

    task automatic check(input logic [63:0] got, input logic [63:0] exp,
                         input string req, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        o   = tdo;
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic shift_bits(input int n, input logic [63:0] din,
                              input logic exit_last, output logic [63:0] dout);
        logic o;
        dout = '0;
        for (int i = 0; i < n; i++) begin
            step(exit_last && (i == n - 1), din[i], o);
            dout[i] = o;
        end
    endtask

    logic en_seen;

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        en_seen = tdo_en;
        shift_bits(n, din, 1'b1, dout);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [3:0] op, output logic [63:0] cap);
        logic o;
        step(1'b1, 1'b0, o);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        shift_bits(4, {60'h0, op}, 1'b1, cap);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] d, a, b;
        logic o;
        repeat (3) @(negedge tck);
        #1;
        check({62'h0, tdo_en, tdo}, 64'h0, "R10", "reset outputs");
        check({63'h0, cfg_start}, 64'h0, "R8", "reset start");
        rst_n = 1'b1;
        step(1'b0, 1'b0, o);                       // TLR -> RTI

        // R2/R1: first data scan after reset returns the identification word
        scan_dr(32, 64'h0, d);
        check(d, {32'h0, EXP_ID}, "R1", "id after reset");
        check({63'h0, en_seen}, 64'h1, "R10", "tdo_en in Shift-DR");
        check({62'h0, tdo_en, tdo}, 64'h0, "R10", "outputs idle in RTI");

        // R4: instruction capture pattern
        scan_ir(4'h2, d);
        check(d, 64'h1, "R4", "Capture-IR pattern");

        // Table walk
        for (int k = 0; k < NV; k++) begin
            scan_ir(VEC[k].op, d);
            scan_dr(VEC[k].len, VEC[k].din, d);
            check(d, VEC[k].exp, "R1 R4 R5 R6 R7", $sformatf("vector %0d", k));
        end
        check({56'h0, bsr_po}, 64'h3C, "R6", "SAMPLE update");

        // R6: other instructions leave boundary outputs alone
        scan_ir(4'h2, d);
        scan_dr(32, 64'hFFFF_FFFF, d);
        check({56'h0, bsr_po}, 64'h3C, "R6", "hold under IDCODE");
        scan_ir(4'hF, d);
        scan_dr(8, 64'h55, d);
        check({56'h0, bsr_po}, 64'h3C, "R6", "hold under BYPASS");
        scan_ir(4'h0, d);
        scan_dr(8, 64'hC3, d);
        check({56'h0, bsr_po}, 64'hC3, "R6", "EXTEST update");

        // R2: tms high five edges from inside Shift-DR
        scan_ir(4'hF, d);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        scan_dr(32, 64'h0, d);
        check(d, {32'h0, EXP_ID}, "R2", "id after tms reset");

        // R3: freeze the clock mid-shift and wiggle tms
        scan_ir(4'h2, d);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        shift_bits(4, 64'h0, 1'b0, a);
        tck_run = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tms = ~tms;
            #7;
        end
        tms = 1'b0;
        check({63'h0, tdo_en}, 64'h1, "R3", "still shifting while frozen");
        tck_run = 1'b1;
        shift_bits(28, 64'h0, 1'b1, b);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        check({32'h0, b[27:0], a[3:0]}, {32'h0, EXP_ID}, "R3", "id across frozen clock");

        // R9: disabled configure
        cfg_dis = 1'b1;
        scan_ir(4'h5, d);
        check({63'h0, cfg_start}, 64'h0, "R9", "start blocked");
        cfg_dis = 1'b0;

        // R8: configure pulse, one cycle, and reissue
        scan_ir(4'h5, d);
        check({63'h0, cfg_start}, 64'h1, "R8", "start pulse");
        step(1'b0, 1'b0, o);
        check({63'h0, cfg_start}, 64'h0, "R8", "pulse width");
        scan_ir(4'h5, d);
        check({63'h0, cfg_start}, 64'h1, "R8", "reissue pulse");

        // R2: asynchronous reset restores IDCODE
        scan_ir(4'hF, d);
        #2 rst_n = 1'b0;
        #10 rst_n = 1'b1;
        @(negedge tck);
        #1;
        step(1'b0, 1'b0, o);
        scan_dr(32, 64'h0, d);
        check(d, {32'h0, EXP_ID}, "R2", "id after async reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule